// File: doc/BRIEF.md
# Wake, Interrupt and Reset Controller

This block supervises a processor subsystem. It gathers three kinds of event: a time-of-day alarm match, a timeout from its own CPU watchdog, and a kickstart input such as a keypress. Each event sets a sticky flag. Software enable masks then steer the flags to an active-low interrupt line, to the active-low reset output, or to both. A kickstart or an alarm can also switch on a power-control output, which turns on the system supply. Software turns that output off again when its work is done, and the system shuts down.

The reset output is also a power-on reset. It stays asserted while the power-good input is low. Once power-good is seen high, it stays asserted for a fixed number of further clocks. An event routed to reset uses the same stretcher, so a watchdog or alarm reset always lasts the full hold time. The alarm comparison and the power sensing are outside the block. Both arrive as synchronous inputs. The kickstart input is asynchronous.

Top module: `wake_supervisor`

## Requirements
- R1: While the internal reset is active and just after it releases, `flags_o` is 0, `irq_no` is 1, `pwr_on_o` is 0 and `rst_no` is 0.
- R2: A `wd_reload_i` pulse loads the watchdog with `wd_period_i`. While `wd_en_i` is high, the watchdog flag (bit 1) is set on the clock edge that lies exactly `wd_period_i` edges after the reload edge. A reload before expiry restarts the full count.
- R3: While `wd_en_i` is low, the watchdog count holds and raises no timeout. Counting resumes from the held value when the enable returns.
- R4: Flag bits are bit 0 = alarm, bit 1 = watchdog and bit 2 = kickstart. A flag sets on the edge after its event and stays set until a `flag_clr_i` pulse on its bit. If an event and a clear hit the same bit in the same cycle, the flag ends up set.
- R5: `irq_no` is 0 exactly when some set flag has its `irq_en_i` bit set, and 1 otherwise.
- R6: `kick_raw_i` is synchronised and reacts to its rising edge only. A level held high produces a single kickstart event, so the flag does not set again after it is cleared.
- R7: `pwr_on_o` goes to 1 on a kickstart event when `pwr_src_en_i[0]` is 1, and on an alarm when `pwr_src_en_i[1]` is 1. An event whose source bit is 0 leaves `pwr_on_o` unchanged.
- R8: A `pwr_off_i` pulse clears `pwr_on_o`. If a power-on event arrives in the same cycle, `pwr_on_o` stays 1.
- R9: `rst_no` is 0 while `pwr_good_i` is 0. It stays 0 for exactly RST_HOLD clock periods after `pwr_good_i` is seen high.
- R10: An event whose `rst_en_i` bit is 1 drives `rst_no` to 0 for exactly RST_HOLD clock periods, starting on the edge that sees the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good_i | input | 1 | Synchronous power-good indication |
| alarm_i | input | 1 | Alarm match event, one pulse per match |
| kick_raw_i | input | 1 | Asynchronous kickstart input |
| wd_en_i | input | 1 | Watchdog count enable |
| wd_reload_i | input | 1 | Software reload pulse for the watchdog |
| wd_period_i | input | WD_W | Watchdog reload value in clocks |
| irq_en_i | input | 3 | Per-event interrupt enables |
| rst_en_i | input | 3 | Per-event reset enables |
| pwr_src_en_i | input | 2 | Power-on sources: bit 0 kickstart, bit 1 alarm |
| flag_clr_i | input | 3 | Per-flag clear pulses |
| pwr_off_i | input | 1 | Software power-off pulse |
| flags_o | output | 3 | Latched event flags |
| irq_no | output | 1 | Active-low interrupt |
| rst_no | output | 1 | Active-low reset output |
| pwr_on_o | output | 1 | Power-control output |

## Verification
The bench builds the block with WD_W = 8 and RST_HOLD = 6. With these values a watchdog expiry takes a few cycles and a full reset stretch can be counted cycle by cycle. The power-good release and a routed event reset can therefore both be measured exactly, as can a reload that restarts the count before expiry. A long random phase mixes alarms, clears, power-off pulses and changing masks against a flag and power model. Directed runs cover the held kickstart level, the cases where set and clear collide, and the paused watchdog.

// File: rtl/wsv_pkg.sv
package wsv_pkg;
  localparam int unsigned NEV           = 3;
  localparam int unsigned EV_ALARM      = 0;
  localparam int unsigned EV_WDOG       = 1;
  localparam int unsigned EV_KICK       = 2;
  localparam int unsigned PWR_SRC_KICK  = 0;
  localparam int unsigned PWR_SRC_ALARM = 1;
endpackage

// File: rtl/wsv_kick_sync.sv
module wsv_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[STAGES-1:0], raw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

  // a held level gives one event only
  p_single_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/wsv_wdog.sv
module wsv_wdog #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          reload_i,
  input  logic [CW-1:0] period_i,
  output logic          timeout_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = reload_i || (en_i && (cnt_q != '0));
    cnt_d  = reload_i ? period_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign timeout_o = en_i && !reload_i && (cnt_q == CW'(1));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reload_i) |=> $stable(cnt_q));

  p_to_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

// File: rtl/wsv_stretch.sv
module wsv_stretch #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic trig_i,
  output logic rst_no
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          load, cnt_en;

  always_comb begin
    load   = !pwr_good_i || trig_i;
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? HW'(HOLD) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= HW'(HOLD);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rst_no = pwr_good_i && (cnt_q == '0);

  p_trig_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !rst_no);

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(pwr_good_i));
endmodule

// File: rtl/wsv_route.sv
module wsv_route
  import wsv_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] set_i,
  input  logic [NEV-1:0] clr_i,
  input  logic [NEV-1:0] irq_en_i,
  input  logic [NEV-1:0] rst_en_i,
  input  logic [1:0]     pwr_src_en_i,
  input  logic           pwr_off_i,
  output logic [NEV-1:0] flags_o,
  output logic           irq_no,
  output logic           rst_trig_o,
  output logic           pwr_on_o
);
  logic [NEV-1:0] flags_q, flags_d;
  logic           flag_upd;
  logic           pwr_q, pwr_d, pwr_set, pwr_upd;

  always_comb begin
    flag_upd = |(set_i | clr_i);
    flags_d  = (flags_q & ~clr_i) | set_i;
    pwr_set  = (set_i[EV_KICK]  & pwr_src_en_i[PWR_SRC_KICK]) |
               (set_i[EV_ALARM] & pwr_src_en_i[PWR_SRC_ALARM]);
    pwr_upd  = pwr_set | pwr_off_i;
    pwr_d    = pwr_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (flag_upd) flags_q <= flags_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pwr_q <= 1'b0;
    else if (pwr_upd) pwr_q <= pwr_d;
  end

  assign flags_o    = flags_q;
  assign pwr_on_o   = pwr_q;
  assign irq_no     = ~|(flags_q & irq_en_i);
  assign rst_trig_o = |(set_i & rst_en_i);

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flags_o & $past(flags_o & ~clr_i)) == '0));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

  p_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_set |=> pwr_on_o);

  p_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_off_i && !pwr_set) |=> !pwr_on_o);
endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor
  import wsv_pkg::*;
#(
  parameter int unsigned WD_W        = 16,
  parameter int unsigned RST_HOLD    = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_good_i,
  input  logic            alarm_i,
  input  logic            kick_raw_i,
  input  logic            wd_en_i,
  input  logic            wd_reload_i,
  input  logic [WD_W-1:0] wd_period_i,
  input  logic [NEV-1:0]  irq_en_i,
  input  logic [NEV-1:0]  rst_en_i,
  input  logic [1:0]      pwr_src_en_i,
  input  logic [NEV-1:0]  flag_clr_i,
  input  logic            pwr_off_i,
  output logic [NEV-1:0]  flags_o,
  output logic            irq_no,
  output logic            rst_no,
  output logic            pwr_on_o
);
  logic [1:0]     rsync_q;
  logic           rst_int_n;
  logic           kick_rise, wd_timeout, rst_trig;
  logic [NEV-1:0] ev_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  wsv_kick_sync #(.STAGES(SYNC_STAGES)) u_kick (
    .clk_i(clk_i), .rst_ni(rst_int_n), .raw_i(kick_raw_i), .rise_o(kick_rise));

  wsv_wdog #(.CW(WD_W)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_int_n), .en_i(wd_en_i), .reload_i(wd_reload_i),
    .period_i(wd_period_i), .timeout_o(wd_timeout));

  always_comb begin
    ev_set           = '0;
    ev_set[EV_ALARM] = alarm_i;
    ev_set[EV_WDOG]  = wd_timeout;
    ev_set[EV_KICK]  = kick_rise;
  end

  wsv_route u_route (
    .clk_i(clk_i), .rst_ni(rst_int_n), .set_i(ev_set), .clr_i(flag_clr_i),
    .irq_en_i(irq_en_i), .rst_en_i(rst_en_i), .pwr_src_en_i(pwr_src_en_i),
    .pwr_off_i(pwr_off_i), .flags_o(flags_o), .irq_no(irq_no),
    .rst_trig_o(rst_trig), .pwr_on_o(pwr_on_o));

  wsv_stretch #(.HOLD(RST_HOLD)) u_stretch (
    .clk_i(clk_i), .rst_ni(rst_int_n), .pwr_good_i(pwr_good_i),
    .trig_i(rst_trig), .rst_no(rst_no));

  p_pg_low_r9: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !pwr_good_i |-> !rst_no);
endmodule

// File: tb/wake_supervisor_tb_top.sv
module wake_supervisor_tb_top;
  localparam int unsigned WD_W = 8;
  localparam int unsigned HOLD = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            pg, alarm, kick, wd_en, wd_rl, pwr_off;
  logic [WD_W-1:0] wd_per;
  logic [2:0]      irq_en, rst_en, clr, flags;
  logic [1:0]      psrc;
  logic            irq_n, rst_out_n, pwr_on;

  int errors = 0;
  int checks = 0;
  logic [2:0] m_flags;
  logic       m_pwr;

  always #2.5 clk = ~clk;

  wake_supervisor #(.WD_W(WD_W), .RST_HOLD(HOLD), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .alarm_i(alarm),
    .kick_raw_i(kick), .wd_en_i(wd_en), .wd_reload_i(wd_rl), .wd_period_i(wd_per),
    .irq_en_i(irq_en), .rst_en_i(rst_en), .pwr_src_en_i(psrc),
    .flag_clr_i(clr), .pwr_off_i(pwr_off), .flags_o(flags), .irq_no(irq_n),
    .rst_no(rst_out_n), .pwr_on_o(pwr_on));

  function automatic logic [2:0] nxt_flags(logic [2:0] f, logic [2:0] s, logic [2:0] c);
    return (f & ~c) | s;
  endfunction
  function automatic logic nxt_pwr(logic p, logic a, logic k, logic [1:0] src, logic off);
    if ((k && src[0]) || (a && src[1])) return 1'b1;
    if (off) return 1'b0;
    return p;
  endfunction
  function automatic logic exp_irq_n(logic [2:0] f, logic [2:0] en);
    return ~|(f & en);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    clr = 3'b111; pwr_off = 1'b1; cyc(1);
    clr = 3'b000; pwr_off = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(100000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; pg = 1'b1; alarm = 0; kick = 0; wd_en = 0; wd_rl = 0;
    wd_per = '0; irq_en = '0; rst_en = '0; psrc = '0; clr = '0; pwr_off = 0;
    cyc(3);
    rst_n = 1'b1;
    #1;
    chk("R1 flags", flags, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 pwr_on", pwr_on, 0);
    chk("R1 rst_n", rst_out_n, 0);
    cyc(HOLD + 6);
    chk("R9 released after reset", rst_out_n, 1);

    // random phase: alarms, clears, power-off, masks
    m_flags = '0; m_pwr = 1'b0;
    for (int i = 0; i < 400; i++) begin
      alarm   = ($urandom % 4) == 0;
      clr     = {($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0};
      pwr_off = ($urandom % 7) == 0;
      irq_en  = 3'($urandom);
      psrc    = 2'($urandom);
      @(posedge clk);
      m_pwr   = nxt_pwr(m_pwr, alarm, 1'b0, psrc, pwr_off);
      m_flags = nxt_flags(m_flags, {2'b00, alarm}, clr);
      @(negedge clk);
      chk("R4 flags random", flags, m_flags);
      chk("R5 irq random", irq_n, exp_irq_n(m_flags, irq_en));
      chk("R7/R8 pwr random", pwr_on, m_pwr);
    end
    alarm = 0; clr = 0; pwr_off = 0; irq_en = 0; psrc = 0;
    clear_all();

    // R4 set wins over clear
    alarm = 1; clr = 3'b001; cyc(1);
    alarm = 0; clr = 0;
    chk("R4 set beats clear", flags[0], 1);
    cyc(3);
    chk("R4 sticky", flags[0], 1);
    clr = 3'b001; cyc(1); clr = 0;
    chk("R4 cleared", flags[0], 0);

    // R8 power-on event beats power-off
    psrc = 2'b10; alarm = 1; pwr_off = 1; cyc(1);
    alarm = 0; pwr_off = 0;
    chk("R8 set beats off", pwr_on, 1);
    pwr_off = 1; cyc(1); pwr_off = 0;
    chk("R8 off clears", pwr_on, 0);
    // R7 masked alarm source
    psrc = 2'b01; alarm = 1; cyc(1); alarm = 0;
    chk("R7 masked alarm", pwr_on, 0);
    clear_all();

    // R2 watchdog expiry
    wd_en = 1; wd_per = 8'd5; wd_rl = 1; cyc(1); wd_rl = 0;
    for (int i = 1; i < 5; i++) begin
      cyc(1);
      chk("R2 before expiry", flags[1], 0);
    end
    cyc(1);
    chk("R2 expiry edge", flags[1], 1);
    clear_all();
    // R2 re-reload restarts
    wd_rl = 1; cyc(1); wd_rl = 0;
    cyc(3);
    wd_rl = 1; cyc(1); wd_rl = 0;
    for (int i = 1; i < 5; i++) begin
      cyc(1);
      chk("R2 restarted count", flags[1], 0);
    end
    cyc(1);
    chk("R2 restarted expiry", flags[1], 1);
    clear_all();
    // R3 paused watchdog
    wd_en = 0; wd_per = 8'd4; wd_rl = 1; cyc(1); wd_rl = 0;
    cyc(12);
    chk("R3 no timeout when paused", flags[1], 0);
    wd_en = 1;
    for (int i = 1; i < 4; i++) begin
      cyc(1);
      chk("R3 resumed count", flags[1], 0);
    end
    cyc(1);
    chk("R3 resumed expiry", flags[1], 1);
    wd_en = 0;
    clear_all();

    // R6/R7 kickstart
    psrc = 2'b01; irq_en = 3'b100; kick = 1; cyc(6);
    chk("R6 kick flag", flags[2], 1);
    chk("R7 kick power-on", pwr_on, 1);
    chk("R5 kick irq", irq_n, 0);
    clr = 3'b100; cyc(1); clr = 0;
    cyc(5);
    chk("R6 held level no retrigger", flags[2], 0);
    chk("R5 irq released", irq_n, 1);
    kick = 0; cyc(4);
    pwr_off = 1; cyc(1); pwr_off = 0;
    chk("R8 power off after kick", pwr_on, 0);
    psrc = 0; irq_en = 0;
    clear_all();

    // R9 power-good stretch
    pg = 0; cyc(3); #1;
    chk("R9 low while power bad", rst_out_n, 0);
    begin
      int n;
      n = 0;
      @(negedge clk);
      pg = 1; #1;
      while (!rst_out_n && n < 50) begin
        n++;
        @(negedge clk); #1;
      end
      chk("R9 stretch length", n, HOLD);
    end

    // R10 routed event reset
    cyc(2);
    rst_en = 3'b001; alarm = 1;
    begin
      int n;
      n = 0;
      @(negedge clk); alarm = 0; #1;
      while (!rst_out_n && n < 50) begin
        n++;
        @(negedge clk); #1;
      end
      chk("R10 event reset length", n, HOLD);
    end
    rst_en = 0;
    alarm = 1; cyc(1); alarm = 0; cyc(1);
    chk("R10 unrouted event no reset", rst_out_n, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule